// File: doc/BRIEF.md
# Hardware Thread Context Status Tracker

This block holds the run state of a set of hardware thread contexts in a multithreaded or multiprocessor core. Each context has a two-bit state register and its own command inputs: activate (with a delay), suspend, deallocate and halt. The block keeps every context in a legal state and times delayed activations. It reports which contexts may issue instructions. It also raises one global flag once every context has stopped for good.

The surrounding core drives the commands for each context. It reads the execute-enable vector to decide which threads its scheduler may choose from, and treats the all-halted flag as the signal to end the run. Fetch, register files and the choice between active threads are handled outside this block.

Top module: `thr_ctx_tracker`

## Requirements
- R1: Each context reports its state on a 2-bit field, state_o[2c+1:2c], with the encoding 0 = Unallocated, 1 = Active, 2 = Suspended, 3 = Halted.
- R2: After reset every context is Unallocated, every execute-enable bit is low and all_halted_o is low.
- R3: An activate with delay d, on a context that is neither Active nor Halted, makes the context Active on the d-th rising edge, counting the edge that samples the command. A delay of 0 counts as 1. Until that edge the state does not change. An activate on an Active context has no effect.
- R4: exec_en_o[c] is high exactly when context c is Active.
- R5: Halted is permanent until reset. Activate, suspend and deallocate leave a Halted context unchanged.
- R6: all_halted_o is high exactly when every context is Halted.
- R7: When several commands reach one context on the same edge, halt wins over deallocate, deallocate wins over suspend, and suspend wins over activate.
- R8: Deallocate returns a context that is not Halted to Unallocated on the next edge.
- R9: Suspend turns an Active context into Suspended on the next edge, and leaves Unallocated and Suspended contexts unchanged. A later activate resumes a Suspended context.
- R10: A suspend, deallocate or halt that arrives while a delayed activation is pending cancels that activation, so the context never becomes Active from it.
- R11: Commands to one context do not affect the state of any other context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| act_i | input | NUM_CTX | Activate command, one bit per context |
| act_dly_i | input | NUM_CTX*DLY_W | Activation delay in cycles, DLY_W bits per context |
| susp_i | input | NUM_CTX | Suspend command, one bit per context |
| dealloc_i | input | NUM_CTX | Deallocate command, one bit per context |
| halt_i | input | NUM_CTX | Halt command, one bit per context |
| state_o | output | 2*NUM_CTX | State of each context, encoded as in R1 |
| exec_en_o | output | NUM_CTX | Context may issue instructions |
| all_halted_o | output | 1 | Every context is Halted |

## Verification
The properties assume that commands are synchronous to clk_i and stable around the rising edge. They also assume that act_dly_i is only looked at while the matching act_i bit is high, so a delay value has no meaning on any other cycle. The stimulus changes every input on the falling edge and holds it for one full cycle. It gives each context its own delay field and sends same-cycle command combinations only when the priority order is the thing being checked.

// File: rtl/thr_ctx_pkg.sv
package thr_ctx_pkg;
  typedef enum logic [1:0] {
    CTX_UNALLOC = 2'd0,
    CTX_ACTIVE  = 2'd1,
    CTX_SUSP    = 2'd2,
    CTX_HALTED  = 2'd3
  } ctx_state_e;
endpackage

// File: rtl/ctx_delay_timer.sv
module ctx_delay_timer #(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             cancel_i,
  output logic             fire_o
);
  logic             busy_q;
  logic [DLY_W-1:0] cnt_q;

  assign fire_o = busy_q && (cnt_q == DLY_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (cancel_i) begin
      busy_q <= 1'b0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= dly_i - DLY_W'(1);
    end else if (busy_q) begin
      if (cnt_q == DLY_W'(1)) busy_q <= 1'b0;
      else                    cnt_q  <= cnt_q - DLY_W'(1);
    end
  end
endmodule

// File: rtl/ctx_state_fsm.sv
module ctx_state_fsm
  import thr_ctx_pkg::*;
#(
  parameter int DLY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic [DLY_W-1:0] dly_i,
  input  logic             susp_i,
  input  logic             dealloc_i,
  input  logic             halt_i,
  output ctx_state_e       state_o,
  output logic             exec_en_o
);
  ctx_state_e st_q, st_d;
  logic live, act_eff, dly_short, fire, tmr_start, tmr_cancel;

  assign live      = (st_q != CTX_HALTED);
  assign dly_short = (dly_i <= DLY_W'(1));
  // activate only counts when no stronger command is present
  assign act_eff   = live && act_i && !halt_i && !dealloc_i && !susp_i && (st_q != CTX_ACTIVE);
  assign tmr_start = act_eff && !dly_short;
  assign tmr_cancel = halt_i || (live && (dealloc_i || susp_i)) || (act_eff && dly_short);

  ctx_delay_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .dly_i   (dly_i),
    .cancel_i(tmr_cancel),
    .fire_o  (fire)
  );

  always_comb begin
    st_d = st_q;
    if (halt_i)                  st_d = CTX_HALTED;
    else if (!live)              st_d = st_q;
    else if (dealloc_i)          st_d = CTX_UNALLOC;
    else if (susp_i) begin
      if (st_q == CTX_ACTIVE)    st_d = CTX_SUSP;
    end else if (act_eff) begin
      if (dly_short)             st_d = CTX_ACTIVE;
    end else if (fire)           st_d = CTX_ACTIVE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= CTX_UNALLOC;
    else         st_q <= st_d;
  end

  assign state_o   = st_q;
  assign exec_en_o = (st_q == CTX_ACTIVE);
endmodule

// File: rtl/thr_ctx_tracker.sv
module thr_ctx_tracker
  import thr_ctx_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int DLY_W   = 4
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CTX-1:0]         act_i,
  input  logic [NUM_CTX*DLY_W-1:0]   act_dly_i,
  input  logic [NUM_CTX-1:0]         susp_i,
  input  logic [NUM_CTX-1:0]         dealloc_i,
  input  logic [NUM_CTX-1:0]         halt_i,
  output logic [2*NUM_CTX-1:0]       state_o,
  output logic [NUM_CTX-1:0]         exec_en_o,
  output logic                       all_halted_o
);
  logic [NUM_CTX-1:0] halted;

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    ctx_state_e st;
    ctx_state_fsm #(.DLY_W(DLY_W)) u_fsm (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .act_i    (act_i[c]),
      .dly_i    (act_dly_i[c*DLY_W +: DLY_W]),
      .susp_i   (susp_i[c]),
      .dealloc_i(dealloc_i[c]),
      .halt_i   (halt_i[c]),
      .state_o  (st),
      .exec_en_o(exec_en_o[c])
    );
    assign state_o[2*c +: 2] = st;
    assign halted[c]         = (st == CTX_HALTED);
  end

  assign all_halted_o = &halted;
endmodule

// File: rtl/thr_ctx_tracker_chk.sv
module thr_ctx_tracker_chk #(
  parameter int NUM_CTX = 4,
  parameter int DLY_W   = 4
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [NUM_CTX-1:0]       act_i,
  input logic [NUM_CTX*DLY_W-1:0] act_dly_i,
  input logic [NUM_CTX-1:0]       susp_i,
  input logic [NUM_CTX-1:0]       dealloc_i,
  input logic [NUM_CTX-1:0]       halt_i,
  input logic [2*NUM_CTX-1:0]     state_o,
  input logic [NUM_CTX-1:0]       exec_en_o,
  input logic                     all_halted_o
);
  logic every_halted;
  always_comb begin
    every_halted = 1'b1;
    for (int c = 0; c < NUM_CTX; c++)
      if (state_o[2*c +: 2] != 2'd3) every_halted = 1'b0;
  end

  p_all_halted_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    all_halted_o == every_halted);

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_chk
    logic [1:0] st;
    assign st = state_o[2*c +: 2];

    p_exec_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_en_o[c] == (st == 2'd1));

    p_halt_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      st == 2'd3 |=> st == 2'd3);

    p_halt_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      halt_i[c] |=> st == 2'd3);

    p_dealloc_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dealloc_i[c] && !halt_i[c] && st != 2'd3 |=> st == 2'd0);

    p_suspend_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      susp_i[c] && !halt_i[c] && !dealloc_i[c] && st == 2'd1 |=> st == 2'd2);

    p_fast_act_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      act_i[c] && act_dly_i[c*DLY_W +: DLY_W] <= DLY_W'(1) && !halt_i[c]
      && !dealloc_i[c] && !susp_i[c] && st != 2'd3 |=> st == 2'd1);
  end
endmodule

bind thr_ctx_tracker thr_ctx_tracker_chk #(.NUM_CTX(NUM_CTX), .DLY_W(DLY_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .act_i       (act_i),
  .act_dly_i   (act_dly_i),
  .susp_i      (susp_i),
  .dealloc_i   (dealloc_i),
  .halt_i      (halt_i),
  .state_o     (state_o),
  .exec_en_o   (exec_en_o),
  .all_halted_o(all_halted_o)
);

// File: tb/thr_ctx_tracker_tb_top.sv
module thr_ctx_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;
  localparam int W = 4;
  localparam int K_ST = 0, K_EX = 1, K_AH = 2;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [N-1:0]     act_v = '0, susp_v = '0, dealloc_v = '0, halt_v = '0;
  logic [N*W-1:0]   dly_v = '0;
  logic [2*N-1:0]   state_w;
  logic [N-1:0]     exec_w;
  logic             allh_w;

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  typedef struct {
    int    due;
    int    ctx;
    int    kind;
    int    val;
    string tag;
  } exp_t;
  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  thr_ctx_tracker #(.NUM_CTX(N), .DLY_W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .act_i(act_v), .act_dly_i(dly_v),
    .susp_i(susp_v), .dealloc_i(dealloc_v), .halt_i(halt_v),
    .state_o(state_w), .exec_en_o(exec_w), .all_halted_o(allh_w)
  );

  function automatic void chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0d expected=%0d", tag, cyc, act, expv);
    end
  endfunction

  function automatic int observe(int kind, int c);
    if (kind == K_ST) return int'(state_w[2*c +: 2]);
    if (kind == K_EX) return int'(exec_w[c]);
    return int'(allh_w);
  endfunction

  // monitor: compare due scoreboard items away from the active edge
  always @(negedge clk) begin
    for (int i = sb_q.size() - 1; i >= 0; i--) begin
      if (sb_q[i].due == cyc) begin
        chk(sb_q[i].tag, observe(sb_q[i].kind, sb_q[i].ctx), sb_q[i].val);
        sb_q.delete(i);
      end
    end
  end

  task automatic push(int k, int c, int kind, int v, string tag);
    exp_t e;
    e.due = cyc + k; e.ctx = c; e.kind = kind; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic tick();
    @(negedge clk);
    act_v = '0; susp_v = '0; dealloc_v = '0; halt_v = '0; dly_v = '0;
  endtask

  task automatic cmd(int c, bit a, int d, bit s, bit dl, bit h);
    act_v[c] = a; susp_v[c] = s; dealloc_v[c] = dl; halt_v[c] = h;
    dly_v[c*W +: W] = W'(d);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    tick();
    for (int c = 0; c < N; c++) begin
      chk("R2 reset state", observe(K_ST, c), 0);
      chk("R2 reset exec", observe(K_EX, c), 0);
    end
    chk("R2 reset all_halted", observe(K_AH, 0), 0);

    // R1/R3: delay 1 activates on the sampling edge
    cmd(0, 1, 1, 0, 0, 0);
    push(1, 0, K_ST, 1, "R1 R3 delay1");
    push(1, 0, K_EX, 1, "R4 exec on active");
    tick();
    // R3: delay 5 exact edge; R11: ctx0 unaffected
    cmd(1, 1, 5, 0, 0, 0);
    push(4, 1, K_ST, 0, "R3 delay5 early");
    push(4, 1, K_EX, 0, "R4 no exec while pending");
    push(5, 1, K_ST, 1, "R3 delay5 on time");
    push(3, 0, K_ST, 1, "R11 neighbour unchanged");
    tick();
    cmd(2, 1, 0, 0, 0, 0);
    push(1, 2, K_ST, 1, "R3 delay0 as 1");
    tick();
    repeat (5) tick();

    // R3: activate on active context has no effect
    cmd(1, 1, 3, 0, 0, 0);
    push(1, 1, K_ST, 1, "R3 reactivate ignored");
    push(3, 1, K_ST, 1, "R3 reactivate ignored late");
    tick(); repeat (3) tick();

    // R9: suspend active and unallocated
    cmd(0, 0, 0, 1, 0, 0);
    push(1, 0, K_ST, 2, "R9 suspend active");
    push(1, 0, K_EX, 0, "R4 no exec suspended");
    cmd(3, 0, 0, 1, 0, 0);
    push(1, 3, K_ST, 0, "R9 suspend unallocated");
    tick(); tick();
    cmd(0, 1, 2, 0, 0, 0);
    push(1, 0, K_ST, 2, "R9 resume pending");
    push(2, 0, K_ST, 1, "R9 resume delay2");
    tick(); tick(); tick();

    // R10: suspend cancels pending
    cmd(3, 1, 4, 0, 0, 0);
    tick();
    cmd(3, 0, 0, 1, 0, 0);
    push(6, 3, K_ST, 0, "R10 suspend cancels");
    tick(); repeat (6) tick();
    // R10: deallocate cancels pending; R8
    cmd(3, 1, 3, 0, 0, 0);
    tick();
    cmd(3, 0, 0, 0, 1, 0);
    push(5, 3, K_ST, 0, "R10 dealloc cancels");
    tick();
    cmd(2, 0, 0, 0, 1, 0);
    push(1, 2, K_ST, 0, "R8 dealloc active");
    push(1, 2, K_EX, 0, "R8 dealloc exec");
    tick(); repeat (5) tick();

    // R7: same-cycle priority
    cmd(2, 1, 1, 0, 0, 0);
    tick(); tick();
    cmd(2, 1, 1, 1, 1, 1);
    push(1, 2, K_ST, 3, "R7 halt wins");
    cmd(0, 1, 1, 1, 1, 0);
    push(1, 0, K_ST, 0, "R7 dealloc over suspend");
    cmd(1, 1, 1, 1, 0, 0);
    push(1, 1, K_ST, 2, "R7 suspend over activate");
    tick(); tick();

    // R5: halted ignores everything
    cmd(2, 1, 1, 0, 0, 0);
    push(1, 2, K_ST, 3, "R5 halted ignores activate");
    tick();
    cmd(2, 0, 0, 0, 1, 0);
    push(1, 2, K_ST, 3, "R5 halted ignores dealloc");
    tick();
    cmd(2, 0, 0, 1, 0, 0);
    push(1, 2, K_ST, 3, "R5 halted ignores suspend");
    push(1, 0, K_AH, 0, "R6 not all halted");
    tick(); tick();

    // R10: halt cancels pending
    cmd(3, 1, 6, 0, 0, 0);
    tick(); tick();
    cmd(3, 0, 0, 0, 0, 1);
    push(1, 3, K_ST, 3, "R10 halt cancels");
    push(6, 3, K_ST, 3, "R10 halt cancels late");
    push(6, 3, K_EX, 0, "R10 no exec after cancel");
    tick(); repeat (6) tick();

    // R6: all halted
    cmd(0, 0, 0, 0, 0, 1);
    push(1, 0, K_AH, 0, "R6 three halted");
    tick();
    cmd(1, 0, 0, 0, 0, 1);
    push(1, 0, K_AH, 1, "R6 all halted");
    push(1, 1, K_EX, 0, "R4 exec off halted");
    tick(); tick();
    repeat (4) tick();

    total++;
    if (sb_q.size() != 0) begin
      bad++;
      $display("FAIL scoreboard left=%0d expected=0", sb_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule